// File: doc/BRIEF.md
# Floating-Point Status Word Unit

This block holds the 32-bit status word of a floating-point unit and updates it as operations retire. The arithmetic datapath sits elsewhere. After each operation it hands over a five-bit exception vector. After each comparison it also supplies a two-bit relation code, a five-bit condition mask and a compare index.

The unit does four things with these inputs:
- It ORs the exceptions into sticky bits at the top of the word.
- It raises a one-cycle trap request when a raised exception has its enable bit set.
- It records each compare outcome, either into one addressed bit or by pushing it into a shifting compare queue.
- It decodes the rounding-mode field and the flush-to-zero control for the arithmetic units.

Software loads the word through a plain write port, and the word is always visible on the `status` output.

Top module: `fp_status_unit`

## Requirements
- R1: When `wr_en` is high, `status` takes `wr_data` at the next clock edge, and `trap_req` is low in the following cycle. A write takes priority over any event presented in the same cycle, and that event has no effect.
- R2: An event's exception vector (bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) is ORed into status bits 27, 28, 29, 30 and 31 respectively. Bits already set stay set.
- R3: `trap_req` is high in the cycle after an event exactly when some raised exception bit i (the vector including any R8 invalid) has status enable bit i (bit 0 to bit 4) set. Otherwise it is low.
- R4: An event that is not a compare and raises no exception leaves `status` unchanged. With no event and no write, `status` holds.
- R5: A compare's result bit is mask bit 4 for relation code 0 (greater), mask bit 3 for code 1 (less), mask bit 2 for code 2 (equal) and mask bit 1 for code 3 (unordered).
- R6: A compare with index k from 1 to 11 writes its result into status bit 22-k and changes no other bit from 11 to 26. An index of 12 to 15 writes no compare bit.
- R7: A compare with index 0 makes three changes: bits 20..11 take the old bits 21..12, bit 21 takes the old bit 26, and bit 26 takes the result.
- R8: A compare with mask bit 0 set and relation unordered raises the invalid exception. This applies the R2 and R3 rules, and the exception update is combined with the compare bit update in the same cycle. With mask bit 0 clear, an unordered compare raises nothing.
- R9: `round_sel` is one-hot, decoded from status bits 10:9. Field 0 sets bit 0 (nearest-even), field 1 sets bit 1 (toward zero), field 2 sets bit 2 (toward +inf) and field 3 sets bit 3 (toward -inf). `flush_en` equals status bit 5.
- R10: After reset, `status` is zero, `trap_req` is low and `round_sel` selects nearest-even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software load of the status word |
| wr_data | input | 32 | Value to load |
| ev_valid | input | 1 | An operation or compare retires this cycle |
| ev_is_cmp | input | 1 | The event is a compare |
| ev_flags | input | 5 | Exception vector of the event |
| ev_rel | input | 2 | Compare relation: 0 greater, 1 less, 2 equal, 3 unordered |
| ev_mask | input | 5 | Compare condition mask; bit 0 selects signaling |
| ev_idx | input | 4 | Compare index: 0 queued, 1..11 targeted |
| status | output | 32 | Current status word |
| trap_req | output | 1 | Enabled exception raised by the previous event |
| round_sel | output | 4 | One-hot rounding mode |
| flush_en | output | 1 | Flush-to-zero enable |

## Verification
The assertions assume the inputs follow two rules:
- The compare fields matter only when `ev_is_cmp` is high.
- The trap request follows only from an accepted event.

The trap assertion also assumes that a write and an event in the same cycle resolve in favour of the write.

The directed stimulus applies inputs on the falling edge and holds them for exactly one cycle. It exercises simultaneous write and event on purpose, covers every index range (queued, targeted and out of range), and pairs every relation code with masks that select both result values.

// File: rtl/fp_status_unit.sv
module fp_status_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        ev_valid,
  input  logic        ev_is_cmp,
  input  logic [4:0]  ev_flags,
  input  logic [1:0]  ev_rel,
  input  logic [4:0]  ev_mask,
  input  logic [3:0]  ev_idx,
  output logic [31:0] status,
  output logic        trap_req,
  output logic [3:0]  round_sel,
  output logic        flush_en
);
  localparam int EXC_LSB = 27;
  localparam int CQ_MSB  = 21;
  localparam int CQ_LSB  = 11;
  localparam int CBIT    = 26;
  localparam int RM_LSB  = 9;
  localparam int FTZ_BIT = 5;
  localparam int N_TGT   = CQ_MSB - CQ_LSB + 1;

  logic        sig_unord;
  logic [4:0]  raised;
  logic        cmp_bit;
  logic [31:0] after_exc;
  logic [31:0] next_w;

  assign sig_unord = ev_is_cmp && ev_mask[0] && (ev_rel == 2'd3);
  assign raised    = ev_valid ? (ev_flags | {sig_unord, 4'b0000}) : 5'b0;
  assign after_exc = status | ({27'b0, raised} << EXC_LSB);

  always_comb begin
    case (ev_rel)
      2'd0:    cmp_bit = ev_mask[4];
      2'd1:    cmp_bit = ev_mask[3];
      2'd2:    cmp_bit = ev_mask[2];
      default: cmp_bit = ev_mask[1];
    endcase
  end

  always_comb begin
    next_w = after_exc;
    if (ev_valid && ev_is_cmp) begin
      if (ev_idx == 4'd0) begin
        next_w[CQ_MSB-1:CQ_LSB] = after_exc[CQ_MSB:CQ_LSB+1];
        next_w[CQ_MSB]          = after_exc[CBIT];
        next_w[CBIT]            = cmp_bit;
      end else begin
        for (int k = 1; k <= N_TGT; k++)
          if (ev_idx == 4'(k)) next_w[CQ_MSB+1-k] = cmp_bit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status   <= '0;
      trap_req <= 1'b0;
    end else if (wr_en) begin
      status   <= wr_data;
      trap_req <= 1'b0;
    end else begin
      status   <= next_w;
      trap_req <= |(raised & status[4:0]);
    end
  end

  always_comb begin
    case (status[RM_LSB+1:RM_LSB])
      2'd0:    round_sel = 4'b0001;
      2'd1:    round_sel = 4'b0010;
      2'd2:    round_sel = 4'b0100;
      default: round_sel = 4'b1000;
    endcase
  end
  assign flush_en = status[FTZ_BIT];

  p_write_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (status == $past(wr_data)) && !trap_req);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status[31:27] & $past(status[31:27])) == $past(status[31:27])));

  p_trap_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(ev_valid && !wr_en));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ev_valid) |=> $stable(status) && !trap_req);

  p_target_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ev_valid && ev_is_cmp && ev_idx != 4'd0) |=>
      $onehot0(status[21:11] ^ $past(status[21:11])) && $stable(status[26]));

  p_queue_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ev_valid && ev_is_cmp && ev_idx == 4'd0) |=>
      (status[20:11] == $past(status[21:12])) && (status[21] == $past(status[26])));

  p_round_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(round_sel) == 1);
endmodule

// File: tb/fp_status_unit_test.sv
`timescale 1ns/1ps
module fp_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ev_valid = 1'b0;
  logic        ev_is_cmp = 1'b0;
  logic [4:0]  ev_flags = '0;
  logic [1:0]  ev_rel = '0;
  logic [4:0]  ev_mask = '0;
  logic [3:0]  ev_idx = '0;
  logic [31:0] status;
  logic        trap_req;
  logic [3:0]  round_sel;
  logic        flush_en;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_w = '0;
  logic        exp_t = 1'b0;
  bit          finished = 0;

  always #2 clk = ~clk;

  fp_status_unit uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] w, input logic cmp,
      input logic [4:0] fl, input logic [1:0] rel, input logic [4:0] m,
      input logic [3:0] idx, output logic t);
    logic [4:0] r;
    logic b;
    logic [31:0] n;
    r = fl;
    if (cmp && m[0] && rel == 2'd3) r[4] = 1'b1;
    t = |(r & w[4:0]);
    n = w | ({27'b0, r} << 27);
    b = m[4 - rel];
    if (cmp) begin
      if (idx == 0) begin
        n[20:11] = w[21:12];
        n[21] = w[26];
        n[26] = b;
      end else if (idx <= 11) begin
        n[22 - idx] = b;
      end
    end
    return n;
  endfunction

  task automatic step(input string req, input logic wr, input logic [31:0] wd,
      input logic v, input logic cmp, input logic [4:0] fl, input logic [1:0] rel,
      input logic [4:0] m, input logic [3:0] idx);
    logic t;
    logic [31:0] n;
    @(negedge clk);
    wr_en = wr; wr_data = wd; ev_valid = v; ev_is_cmp = cmp;
    ev_flags = fl; ev_rel = rel; ev_mask = m; ev_idx = idx;
    t = 1'b0;
    if (wr) n = wd;
    else if (v) n = model(exp_w, cmp, fl, rel, m, idx, t);
    else n = exp_w;
    exp_w = n; exp_t = t;
    @(negedge clk);
    wr_en = 0; ev_valid = 0; ev_is_cmp = 0;
    chk({req, " status"}, status, exp_w);
    chk({req, " trap"}, {31'b0, trap_req}, {31'b0, exp_t});
  endtask

  task automatic t_reset();
    chk("R10 status", status, 32'h0);
    chk("R10 trap", {31'b0, trap_req}, 32'h0);
    chk("R10 round", {28'b0, round_sel}, 32'h1);
  endtask

  task automatic t_write_decode();
    step("R1", 1, 32'h0000_0620, 0, 0, 0, 0, 0, 0);
    chk("R9 round down", {28'b0, round_sel}, 32'h8);
    chk("R9 flush on", {31'b0, flush_en}, 32'h1);
    step("R1", 1, 32'h0000_0200, 0, 0, 0, 0, 0, 0);
    chk("R9 round zero", {28'b0, round_sel}, 32'h2);
    chk("R9 flush off", {31'b0, flush_en}, 32'h0);
    step("R1", 1, 32'h0000_0400, 0, 0, 0, 0, 0, 0);
    chk("R9 round up", {28'b0, round_sel}, 32'h4);
  endtask

  task automatic t_sticky();
    step("R1", 1, 32'h0, 0, 0, 0, 0, 0, 0);
    step("R2 map", 0, 0, 1, 0, 5'b00101, 0, 0, 0);
    chk("R2 bits 27 29", status, 32'h2800_0000);
    step("R2 sticky", 0, 0, 1, 0, 5'b00010, 0, 0, 0);
    step("R2 invalid+div", 0, 0, 1, 0, 5'b11000, 0, 0, 0);
    chk("R2 all", status, 32'hF800_0000);
  endtask

  task automatic t_no_effect();
    step("R1", 1, 32'h0123_4560, 0, 0, 0, 0, 0, 0);
    step("R4 zero flags", 0, 0, 1, 0, 5'b0, 2'd1, 5'b11111, 4'd0);
    step("R4 idle", 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_trap();
    step("R1", 1, 32'h0000_0008, 0, 0, 0, 0, 0, 0);
    step("R3 enabled", 0, 0, 1, 0, 5'b01000, 0, 0, 0);
    step("R3 disabled flag", 0, 0, 1, 0, 5'b00001, 0, 0, 0);
    step("R3 idle after", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 32'h0000_001F, 0, 0, 0, 0, 0, 0);
    step("R3 any enable", 0, 0, 1, 0, 5'b00100, 0, 0, 0);
  endtask

  task automatic t_targeted();
    step("R1", 1, 32'h0, 0, 0, 0, 0, 0, 0);
    step("R5 greater R6 idx1", 0, 0, 1, 1, 0, 2'd0, 5'b10000, 4'd1);
    chk("R6 bit21", status, 32'h0020_0000);
    step("R5 less R6 idx11", 0, 0, 1, 1, 0, 2'd1, 5'b01000, 4'd11);
    step("R5 equal R6 idx5", 0, 0, 1, 1, 0, 2'd2, 5'b00100, 4'd5);
    chk("R6 bits", status, 32'h0022_0800);
    step("R5 unordered clear", 0, 0, 1, 1, 0, 2'd3, 5'b11100, 4'd1);
    step("R5 mask mismatch", 0, 0, 1, 1, 0, 2'd0, 5'b01110, 4'd11);
    step("R6 idx13 no bit", 0, 0, 1, 1, 0, 2'd0, 5'b10000, 4'd13);
  endtask

  task automatic t_queue();
    step("R1", 1, 32'h0420_5000, 0, 0, 0, 0, 0, 0);
    step("R7 push one", 0, 0, 1, 1, 0, 2'd2, 5'b00100, 4'd0);
    step("R7 push zero", 0, 0, 1, 1, 0, 2'd0, 5'b01000, 4'd0);
    step("R7 push flags", 0, 0, 1, 1, 5'b00001, 2'd1, 5'b01000, 4'd0);
    for (int i = 0; i < 12; i++)
      step("R7 run", 0, 0, 1, 1, 0, 2'(i % 4), 5'(i * 7), 4'd0);
  endtask

  task automatic t_signaling();
    step("R1", 1, 32'h0000_0010, 0, 0, 0, 0, 0, 0);
    step("R8 quiet unordered", 0, 0, 1, 1, 0, 2'd3, 5'b00010, 4'd2);
    step("R8 signaling", 0, 0, 1, 1, 0, 2'd3, 5'b00011, 4'd2);
    chk("R8 invalid set", {31'b0, status[31]}, 32'h1);
    step("R8 signaling ordered", 0, 0, 1, 1, 0, 2'd2, 5'b00101, 4'd0);
  endtask

  task automatic t_priority();
    step("R1", 1, 32'h0, 0, 0, 0, 0, 0, 0);
    step("R1 write wins", 1, 32'h0000_001F, 1, 1, 5'b11111, 2'd0, 5'b10000, 4'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_decode();
    t_sticky();
    t_no_effect();
    t_trap();
    t_targeted();
    t_queue();
    t_signaling();
    t_priority();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule